// File: doc/BRIEF.md
# Column-Associative Rehash Cache

This block is a read-only line cache built on one direct-mapped array. A request carries a line address. The low index bits select a primary slot, which is probed first. If that probe misses, the same array is read a second time at a partner slot. The partner slot is the primary index with its most significant bit inverted, so every pair of slots behaves like a two-way set. A line found in the partner slot is swapped into its primary slot.

Each slot carries a displaced flag. The flag is set when a line was moved into the slot because another line took the slot that line had occupied. When a primary slot holds a valid line with this flag set, the second probe is skipped and the new line overwrites that slot. This stops two hot lines from bouncing between the slots of one pair. When both probes miss, the block issues a fill request to memory. The fetched line goes into the primary slot, and the line that was there moves to the partner slot.

The stored tag includes the index MSB, so a tag comparison at either slot identifies the line without ambiguity. Only reads are handled.

Top module: `cra_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `fill_req_valid` are 0, and every slot is invalid, so the first access to any line never returns a hit.
- R2: A first-probe hit raises `rsp_valid` in the cycle after the request is accepted, with the stored data and `rsp_src` = 0.
- R3: If the first probe misses and the primary slot is invalid or not flagged displaced, the slot at the index with its MSB inverted is probed. A hit there raises `rsp_valid` two cycles after acceptance, with `rsp_src` = 1.
- R4: On a second-probe hit, the two slots exchange contents. The requested line lands in its primary slot with the flag clear, and the former primary occupant lands in the partner slot with the flag set. The next access to the requested line is a first-probe hit, and the next access to the displaced line is a second-probe hit.
- R5: Two lines whose addresses differ only in the index MSB never hit on each other's slot.
- R6: If the primary slot holds a valid line with the displaced flag set and the tag does not match, no second probe is made. `fill_req_valid` rises in the cycle after acceptance, the fill overwrites the primary slot, and the partner slot is left unchanged.
- R7: When both probes miss, `fill_req_valid` rises two cycles after acceptance. It carries the requested address on `fill_req_addr` and stays high until `fill_valid` is seen.
- R8: The cycle after `fill_valid` is accepted, `rsp_valid` rises with `fill_data` and `rsp_src` = 2. The line is installed in its primary slot with the flag clear. A valid former occupant moves to the partner slot with the flag set. An invalid former occupant leaves the partner slot unchanged.
- R9: `req_ready` is low from the acceptance of a request that misses the first probe until that request's response. Hits can be accepted on consecutive cycles.
- R10: `fill_valid` asserted while no fill is outstanding produces no response and changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Line address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | DATA_W | Line data returned |
| rsp_src | output | 2 | 0 = first probe, 1 = second probe, 2 = memory fill |
| fill_req_valid | output | 1 | Memory fill requested |
| fill_req_addr | output | ADDR_W | Line address to fetch |
| fill_valid | input | 1 | Memory returns the fill data |
| fill_data | input | DATA_W | Fetched line data |

## Verification
Each result is due a fixed number of edges after its stimulus:
- a first-probe hit answers in the cycle after acceptance;
- a second-probe hit answers one cycle later than a first-probe hit;
- a fill request appears one cycle after acceptance on the skip path and two cycles after on the normal path;
- a fill answers in the cycle after `fill_valid` is sampled.

When the driver issues a request, it pushes the expected cycle number together with the expected source and data. The monitor samples on the falling edge and compares the cycle counter against that number, so an early or a late response counts as a miscompare. The fill-request timing and address are checked in the same way against the cycle the model predicts.

// File: rtl/cra_pkg.sv
package cra_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE2 = 2'd1,
        ST_FILL   = 2'd2
    } st_e;

    typedef enum logic [1:0] {
        SRC_PRIMARY = 2'd0,
        SRC_PARTNER = 2'd1,
        SRC_FILL    = 2'd2
    } src_e;
endpackage

// File: rtl/cra_store.sv
module cra_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 32,
    localparam int SETS  = 1 << IDX_W,
    localparam int ENT_W = 2 + TAG_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ENT_W-1:0]  rd_ent,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [ENT_W-1:0]  wa_ent,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [ENT_W-1:0]  wb_ent
);
    localparam logic [IDX_W-1:0] MSB_MASK = IDX_W'(1) << (IDX_W - 1);

    logic [ENT_W-1:0] ent_q [SETS];
    logic [ENT_W-1:0] ent_d [SETS];

    always_comb begin
        ent_d = ent_q;
        if (wa_en) ent_d[wa_idx] = wa_ent;
        if (wb_en) ent_d[wb_idx] = wb_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) ent_q[i] <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign rd_ent = ent_q[rd_idx];

    // R4: a dual write always touches the two slots of one pair
    assert_pair_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en) |-> ((wa_idx ^ wb_idx) == MSB_MASK));
endmodule

// File: rtl/cra_match.sv
module cra_match #(
    parameter int TAG_W = 7
) (
    input  logic             ent_vld,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [TAG_W-1:0] want_tag,
    output logic             hit
);
    always_comb hit = ent_vld && (ent_tag == want_tag);
endmodule

// File: rtl/cra_ctrl.sv
module cra_ctrl
    import cra_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    localparam int TAG_W = ADDR_W - IDX_W + 1,
    localparam int ENT_W = 2 + TAG_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_src,
    output logic              fill_req_valid,
    output logic [ADDR_W-1:0] fill_req_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [ENT_W-1:0]  rd_ent,
    output logic [TAG_W-1:0]  want_tag,
    input  logic              hit,
    output logic              wa_en,
    output logic [IDX_W-1:0]  wa_idx,
    output logic [ENT_W-1:0]  wa_ent,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [ENT_W-1:0]  wb_ent
);
    localparam logic [IDX_W-1:0] MSB_MASK = IDX_W'(1) << (IDX_W - 1);

    typedef struct packed {
        logic              vld;
        logic              rh;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } ent_t;

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] addr;
        ent_t              victim;
        logic              skip;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        src_e              rsp_src;
        logic              fill_req;
    } ctl_t;

    ctl_t q, d;
    ent_t cur, wa_s, wb_s;
    logic [IDX_W-1:0] idx1, idx2;
    logic pinned;

    always_comb begin
        cur      = rd_ent;
        idx1     = q.addr[IDX_W-1:0];
        idx2     = idx1 ^ MSB_MASK;
        pinned   = cur.vld && cur.rh;
        rd_idx   = (q.st == ST_IDLE) ? req_addr[IDX_W-1:0] : idx2;
        want_tag = (q.st == ST_IDLE) ? req_addr[ADDR_W-1:IDX_W-1] : q.addr[ADDR_W-1:IDX_W-1];
        d           = q;
        d.rsp_valid = 1'b0;
        wa_en  = 1'b0;
        wa_idx = idx1;
        wa_s   = '0;
        wb_en  = 1'b0;
        wb_idx = idx2;
        wb_s   = q.victim;
        wb_s.rh = 1'b1;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr   = req_addr;
                    d.victim = cur;
                    if (hit) begin
                        d.rsp_valid = 1'b1;
                        d.rsp_data  = cur.data;
                        d.rsp_src   = SRC_PRIMARY;
                    end else if (pinned) begin
                        d.st       = ST_FILL;
                        d.skip     = 1'b1;
                        d.fill_req = 1'b1;
                    end else begin
                        d.st   = ST_PROBE2;
                        d.skip = 1'b0;
                    end
                end
            end
            ST_PROBE2: begin
                if (hit) begin
                    d.rsp_valid = 1'b1;
                    d.rsp_data  = cur.data;
                    d.rsp_src   = SRC_PARTNER;
                    wa_en = 1'b1;
                    wa_s  = '{vld: 1'b1, rh: 1'b0, tag: cur.tag, data: cur.data};
                    wb_en = 1'b1;
                    d.st  = ST_IDLE;
                end else begin
                    d.st       = ST_FILL;
                    d.fill_req = 1'b1;
                end
            end
            ST_FILL: begin
                if (fill_valid) begin
                    d.rsp_valid = 1'b1;
                    d.rsp_data  = fill_data;
                    d.rsp_src   = SRC_FILL;
                    wa_en = 1'b1;
                    wa_s  = '{vld: 1'b1, rh: 1'b0,
                              tag: q.addr[ADDR_W-1:IDX_W-1], data: fill_data};
                    wb_en = !q.skip && q.victim.vld;
                    d.fill_req = 1'b0;
                    d.st       = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        wa_ent = wa_s;
        wb_ent = wb_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready      = (q.st == ST_IDLE);
    assign rsp_valid      = q.rsp_valid;
    assign rsp_data       = q.rsp_data;
    assign rsp_src        = q.rsp_src;
    assign fill_req_valid = q.fill_req;
    assign fill_req_addr  = q.addr;

    assert_primary_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && hit) |=> (rsp_valid && rsp_src == SRC_PRIMARY));
    assert_partner_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PROBE2 && hit) |=> (rsp_valid && rsp_src == SRC_PARTNER && req_ready));
    assert_skip_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !hit && pinned) |=> (fill_req_valid && !rsp_valid));
    assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && !fill_valid) |=> (fill_req_valid && $stable(fill_req_addr)));
    assert_fill_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && fill_valid) |=> (rsp_valid && rsp_src == SRC_FILL
                                            && rsp_data == $past(fill_data)));
    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |-> !req_ready);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> !rsp_valid);
endmodule

// File: rtl/cra_cache.sv
module cra_cache #(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    localparam int TAG_W = ADDR_W - IDX_W + 1,
    localparam int ENT_W = 2 + TAG_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_src,
    output logic              fill_req_valid,
    output logic [ADDR_W-1:0] fill_req_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    logic [IDX_W-1:0] rd_idx, wa_idx, wb_idx;
    logic [ENT_W-1:0] rd_ent, wa_ent, wb_ent;
    logic [TAG_W-1:0] want_tag;
    logic             wa_en, wb_en, hit;

    cra_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_ent(rd_ent),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_ent(wa_ent),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_ent(wb_ent)
    );

    cra_match #(.TAG_W(TAG_W)) u_match (
        .ent_vld (rd_ent[ENT_W-1]),
        .ent_tag (rd_ent[DATA_W +: TAG_W]),
        .want_tag(want_tag),
        .hit     (hit)
    );

    cra_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_src(rsp_src),
        .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .rd_idx(rd_idx), .rd_ent(rd_ent), .want_tag(want_tag), .hit(hit),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_ent(wa_ent),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_ent(wb_ent)
    );
endmodule

// File: tb/tb_cra_cache.sv
module tb_cra_cache;
    localparam int AW = 10;
    localparam int IW = 4;
    localparam int DW = 32;
    localparam int SETS = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready, rsp_valid, fill_req_valid;
    logic [DW-1:0] rsp_data;
    logic [1:0] rsp_src;
    logic [AW-1:0] fill_req_addr;
    logic fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;

    always #10 clk = ~clk;

    cra_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_src(rsp_src),
        .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    src;
        logic [DW-1:0] data;
        int            cyc;
        string         tag;
    } exp_t;

    exp_t sb[$];
    int vectors = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic          mv [SETS];
    logic          mr [SETS];
    logic [AW-1:0] ml [SETS];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return 32'h5A000000 ^ (32'(a) * 32'h00010001);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            if (sb.size() == 0) begin
                check(0, "R10", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_src == e.src, e.tag, "rsp_src", rsp_src, e.src);
                check(rsp_data == e.data, e.tag, "rsp_data", rsp_data, e.data);
                check(cyc == e.cyc, e.tag, "response cycle", cyc, e.cyc);
            end
        end
    end

    // called at a falling edge; returns at a falling edge
    task automatic access(input logic [AW-1:0] a, input string tag);
        logic [IW-1:0] i1, i2;
        int kind, acc, exp_fr, t;
        logic vv;
        logic [AW-1:0] vl;
        exp_t e;
        while (!req_ready) @(negedge clk);
        i1 = a[IW-1:0];
        i2 = i1 ^ IW'(1 << (IW - 1));
        if (mv[i1] && ml[i1] == a)      kind = 0;
        else if (mv[i1] && mr[i1])      kind = 2;
        else if (mv[i2] && ml[i2] == a) kind = 1;
        else                            kind = 3;
        req_valid = 1'b1;
        req_addr  = a;
        acc = cyc + 1;
        e.addr = a; e.tag = tag; e.data = mem_word(a);
        if (kind <= 1) begin
            e.src = kind[1:0];
            e.cyc = acc + kind;
            sb.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (kind == 0) begin
            check(req_ready == 1'b1, "R9", "ready after hit", req_ready, 1);
            return;
        end
        check(req_ready == 1'b0, "R9", "ready during miss", req_ready, 0);
        if (kind == 1) begin
            vv = mv[i1]; vl = ml[i1];
            mv[i1] = 1'b1; mr[i1] = 1'b0; ml[i1] = a;
            mv[i2] = vv;   mr[i2] = 1'b1; ml[i2] = vl;
            @(negedge clk);
            return;
        end
        exp_fr = (kind == 2) ? acc : acc + 1;
        t = 0;
        while (!fill_req_valid && t < 20) begin
            @(negedge clk);
            t++;
        end
        check(cyc == exp_fr, (kind == 2) ? "R6" : "R7", "fill request cycle", cyc, exp_fr);
        check(fill_req_addr == a, "R7", "fill request address", fill_req_addr, a);
        fill_valid = 1'b1;
        fill_data  = mem_word(a);
        e.src = 2'd2;
        e.cyc = cyc + 1;
        sb.push_back(e);
        if (kind == 3 && mv[i1]) begin
            mv[i2] = 1'b1; mr[i2] = 1'b1; ml[i2] = ml[i1];
        end
        mv[i1] = 1'b1; mr[i1] = 1'b0; ml[i1] = a;
        @(negedge clk);
        fill_valid = 1'b0;
        check(fill_req_valid == 1'b0, "R8", "fill request drop", fill_req_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            done = 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < SETS; i++) begin
            mv[i] = 1'b0; mr[i] = 1'b0; ml[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
        check(fill_req_valid == 1'b0, "R1", "reset fill_req", fill_req_valid, 0);
        access(10'h000, "R1");   // all-zero line must still miss
        access(10'h013, "R7");   // invalid slots, full miss
        access(10'h013, "R2");
        access(10'h01B, "R5");   // differs only in index MSB
        access(10'h013, "R5");
        access(10'h01B, "R5");
        access(10'h023, "R8");   // displaces 013 to partner
        access(10'h013, "R3");   // partner hit, swap
        access(10'h013, "R4");
        access(10'h023, "R4");
        access(10'h05B, "R6");   // primary flagged displaced: skip
        access(10'h023, "R6");   // partner slot left untouched
        access(10'h00D, "R8");
        // stray fill strobe while idle
        fill_valid = 1'b1;
        fill_data  = 32'hDEADBEEF;
        @(negedge clk);
        fill_valid = 1'b0;
        check(rsp_valid == 1'b0, "R10", "no response to stray fill", rsp_valid, 0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10", "still no response", rsp_valid, 0);
        access(10'h00D, "R10");
        access(10'h035, "R8");   // invalid primary, partner untouched
        access(10'h00D, "R8");
        access(10'h035, "R9");   // back-to-back hits
        access(10'h00D, "R9");
        access(10'h035, "R9");
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R9", "responses outstanding", sb.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule